// File: doc/BRIEF.md
# Start-up Bias Hysteresis Sequencer

This block sequences the start-up of a power stage whose control electronics run from a bias rail. During start-up the rail is charged through an external pass device. The block turns that device off once the rail has charged and then lets a soft-start pulse generator run. If the rail sags during the ramp, the block stops the ramp and turns the pass device back on to recharge the rail. A bounded number of these retries is allowed. A millisecond timeout covers the whole start-up phase. Both limits end in a shutdown that only a reset clears.

Once the output stage reports that the bulk voltage is near its setpoint, the block enters normal mode. In normal mode it keeps the pass device off, except in light-load burst operation. There, a sagging rail is topped up with hysteresis between the lower and upper comparator flags. The analog comparators and the pulse-width arithmetic sit outside this block. The block sees them only as single-bit flags.

Top module: `startup_bias_seq`

## Requirements
- R1: While reset is asserted and directly after it, `pass_off`, `ramp_en`, `normal_mode` and `shutdown` are all 0 (the pass device is on).
- R2: From the waiting state, `pass_off` rises on the clock edge that samples `bias_hi`=1, and not before.
- R3: `ramp_en` is 1 only while the block is in the ramp state and `line_ok` is 1; `line_ok` acts on `ramp_en` in the same cycle.
- R4: `bias_lo`=1 sampled in the ramp state aborts the ramp: from the next cycle `pass_off` and `ramp_en` are 0 until an edge samples `bias_hi`=1, after which the ramp resumes.
- R5: Each abort below the limit counts as one restart. After RESTART_LIMIT (default 10) restarts, the next abort sets `shutdown` instead of recharging.
- R6: Once `shutdown` is 1 it stays 1 and `pass_off`, `ramp_en`, `normal_mode` stay 0 whatever the inputs, until reset.
- R7: `bulk_done`=1 sampled in the ramp state sets `normal_mode` and `pass_off` and clears `ramp_en` from the next cycle. In the waiting and recharge states `bulk_done` has no effect.
- R8: In normal mode, `bias_lo`=1 with `burst`=1 clears `pass_off` on the next edge. A later `bias_hi`=1 sets it again. `bias_lo` without `burst` has no effect.
- R9: If `burst` falls while the rail is recharging in normal mode, `pass_off` returns to 1 on the next edge.
- R10: Counting from reset, the TIMEOUT_MS-th (default 600) `ms_tick` pulse sampled before normal mode sets `shutdown` on that edge. The timeout takes priority over every other start-up transition. Ticks have no effect in normal mode.
- R11: When `bias_lo` and `bulk_done` are both 1 in the ramp state, `bulk_done` wins and normal mode is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bias_hi | input | 1 | Bias rail above upper threshold |
| bias_lo | input | 1 | Bias rail below lower threshold |
| line_ok | input | 1 | Line above start level |
| bulk_done | input | 1 | Bulk voltage at near-setpoint level |
| burst | input | 1 | Light-load burst mode active |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| pass_off | output | 1 | 1 turns the external start-up device off |
| ramp_en | output | 1 | Enables soft-start pulse generation |
| normal_mode | output | 1 | Start-up complete |
| shutdown | output | 1 | Latched shutdown |

## Verification
The bench walks the restart counter exactly to its limit. An off-by-one counter would latch on the tenth abort or allow a twelfth ramp. It pulses the tick up to one short of the timeout and then exactly on it. This catches a timer that fires early, fires late, or keeps running in normal mode. It drives `bias_lo` and `bulk_done` together, where the wrong priority would send the block back to recharge. It also drops `burst` during a normal-mode recharge, where a design that ignored this would leave the pass device on. Inputs applied after shutdown show whether the latch can be escaped.

// File: rtl/startup_bias_seq.sv
module startup_bias_seq #(
  parameter int RESTART_LIMIT = 10,
  parameter int TIMEOUT_MS    = 600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bias_hi,
  input  logic bias_lo,
  input  logic line_ok,
  input  logic bulk_done,
  input  logic burst,
  input  logic ms_tick,
  output logic pass_off,
  output logic ramp_en,
  output logic normal_mode,
  output logic shutdown
);
  localparam int RW = $clog2(RESTART_LIMIT + 1);
  localparam int TW = $clog2(TIMEOUT_MS);
  localparam logic [RW-1:0] RLIM  = RW'(RESTART_LIMIT);
  localparam logic [TW-1:0] TLAST = TW'(TIMEOUT_MS - 1);

  typedef enum logic [2:0] {
    S_WAIT, S_RAMP, S_RECHG, S_NORM, S_NCHG, S_LATCH
  } st_t;

  st_t st, st_nx;
  logic [RW-1:0] restarts;
  logic [TW-1:0] tmr;

  wire starting = (st == S_WAIT) || (st == S_RAMP) || (st == S_RECHG);
  wire expire   = starting && ms_tick && (tmr == TLAST);
  wire abort    = (st == S_RAMP) && !bulk_done && bias_lo;

  always_comb begin
    st_nx = st;
    if (expire) st_nx = S_LATCH;
    else begin
      unique case (st)
        S_WAIT:  if (bias_hi) st_nx = S_RAMP;
        S_RAMP:
          if (bulk_done) st_nx = S_NORM;
          else if (bias_lo) st_nx = (restarts == RLIM) ? S_LATCH : S_RECHG;
        S_RECHG: if (bias_hi) st_nx = S_RAMP;
        S_NORM:  if (burst && bias_lo) st_nx = S_NCHG;
        S_NCHG:  if (bias_hi || !burst) st_nx = S_NORM;
        default: st_nx = S_LATCH;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= S_WAIT;
      restarts <= '0;
      tmr      <= '0;
    end else begin
      st <= st_nx;
      if (abort && restarts != RLIM) restarts <= restarts + 1'b1;
      if (starting && ms_tick && !expire) tmr <= tmr + 1'b1;
    end

  assign pass_off    = (st == S_RAMP) || (st == S_NORM);
  assign ramp_en     = (st == S_RAMP) && line_ok;
  assign normal_mode = (st == S_NORM) || (st == S_NCHG);
  assign shutdown    = (st == S_LATCH);

  a_r6_latch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> shutdown);
  a_r6_latch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> !pass_off && !ramp_en && !normal_mode);
  a_r3_ramp_needs_off: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_en |-> pass_off && line_ok);
  a_r7_normal_kept: assert property (@(posedge clk) disable iff (!rst_n)
    normal_mode |=> normal_mode);
  a_r2_rise_on_bias: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pass_off) |-> $past(bias_hi) || $past(bulk_done) || !$past(burst));
  a_r4_fall_on_sag: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pass_off) && !shutdown |-> $past(bias_lo));
  a_r9_no_burst_on: assert property (@(posedge clk) disable iff (!rst_n)
    normal_mode && $past(normal_mode) && !$past(burst) |-> pass_off);
endmodule

// File: tb/test_startup_bias_seq.sv
`timescale 1ns/1ps
module test_startup_bias_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bias_hi = 0, bias_lo = 0, line_ok = 0, bulk_done = 0, burst = 0, ms_tick = 0;
  logic pass_off, ramp_en, normal_mode, shutdown;
  int applied = 0;
  int miscmp = 0;

  always #5 clk = ~clk;

  startup_bias_seq i_startup_bias_seq (
    .clk(clk), .rst_n(rst_n), .bias_hi(bias_hi), .bias_lo(bias_lo),
    .line_ok(line_ok), .bulk_done(bulk_done), .burst(burst), .ms_tick(ms_tick),
    .pass_off(pass_off), .ramp_en(ramp_en), .normal_mode(normal_mode),
    .shutdown(shutdown)
  );

  // inputs {bias_hi,bias_lo,line_ok,bulk_done,burst,ms_tick}, expect {pass_off,ramp_en,normal_mode,shutdown}
  localparam int NV = 15;
  localparam logic [9:0] VEC [NV] = '{
    {6'b000000, 4'b0000},  // R1 idle wait
    {6'b001000, 4'b0000},  // R3 line without bias
    {6'b100000, 4'b1000},  // R2 bias up, R3 line low
    {6'b101000, 4'b1100},  // R3 ramp running
    {6'b011000, 4'b0000},  // R4 abort
    {6'b001000, 4'b0000},  // R4 recharging
    {6'b101000, 4'b1100},  // R4 resume
    {6'b011100, 4'b1010},  // R11 bulk wins over sag
    {6'b010000, 4'b1010},  // R8 sag without burst ignored
    {6'b010010, 4'b0010},  // R8 burst sag
    {6'b000010, 4'b0010},  // R8 hold recharge
    {6'b100010, 4'b1010},  // R8 regained
    {6'b010010, 4'b0010},  // R8 sag again
    {6'b000000, 4'b1010},  // R9 burst dropped
    {6'b100101, 4'b1010}   // R10 tick in normal ignored
  };

  task automatic check(input logic [3:0] exp, input string tag);
    logic [3:0] got;
    got = {pass_off, ramp_en, normal_mode, shutdown};
    applied++;
    if (got !== exp) begin
      miscmp++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [5:0] in, input logic [3:0] exp, input string tag);
    {bias_hi, bias_lo, line_ok, bulk_done, burst, ms_tick} = in;
    @(negedge clk);
    check(exp, tag);
  endtask

  task automatic do_reset();
    {bias_hi, bias_lo, line_ok, bulk_done, burst, ms_tick} = '0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #1_000_000;
    miscmp++;
    applied++;
    $display("FAIL watchdog: got hang expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
    $finish;
  end

  initial begin
    @(negedge clk);
    check(4'b0000, "R1 in reset");
    do_reset();
    check(4'b0000, "R1 after reset");
    for (int i = 0; i < NV; i++)
      apply(VEC[i][9:4], VEC[i][3:0], $sformatf("table[%0d]", i));

    // R5 restart limit
    do_reset();
    apply(6'b100000, 4'b1000, "R5 first ramp");
    for (int k = 0; k < 10; k++) begin
      apply(6'b010000, 4'b0000, "R5 abort below limit");
      apply(6'b100000, 4'b1000, "R5 restart");
    end
    apply(6'b010000, 4'b0001, "R5 abort over limit");
    // R6 sticky
    apply(6'b101100, 4'b0001, "R6 inputs ignored");
    apply(6'b100010, 4'b0001, "R6 still latched");

    // R7 bulk ignored while waiting, R10 timeout
    do_reset();
    apply(6'b000100, 4'b0000, "R7 bulk ignored in wait");
    for (int k = 0; k < 599; k++) begin
      {bias_hi, bias_lo, line_ok, bulk_done, burst, ms_tick} = (k == 300) ? 6'b100001 : 6'b000001;
      @(negedge clk);
      ms_tick = 1'b0;
    end
    check(4'b1000, "R10 one tick short");
    apply(6'b000101, 4'b0001, "R10 timeout beats bulk");

    // R10 no timeout once normal
    do_reset();
    apply(6'b100000, 4'b1000, "R2 ramp");
    apply(6'b000100, 4'b1010, "R7 normal");
    for (int k = 0; k < 700; k++) begin
      ms_tick = 1'b1;
      @(negedge clk);
    end
    ms_tick = 1'b0;
    check(4'b1010, "R10 timer frozen in normal");

    $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
    $finish;
  end
endmodule